// File: doc/BRIEF.md
# Iterative Fixed-Point Reciprocal Unit

This block turns a nonzero 16-bit unsigned divisor into a 16-bit reciprocal of the divisor's normalized form. It reports the leading-zero count it used for normalization. A divide datapath can then form a quotient estimate with one more high-half multiply and undo the normalization with that count. The divisor is shifted left until its top bit is set. A coarse byte-wide estimate is picked from an eight-entry seed table, using the three bits that follow the leading one. The estimate is then refined by a fixed number of Newton iterations.

The refinement uses only W×W high-half products and a modular negate. It shares one multiplier across all the multiplies, so a request takes a few cycles. A single-cycle `start` pulse begins a request and a single-cycle `done` pulse ends it. A zero divisor is flagged as an error instead of being processed.

Top module: `nr_recip`

## Requirements
- R1: After reset `done`, `busy` and `err` are 0, and `recip` and `lzc` are 0.
- R2: `lzc` equals the number of leading zero bits of the accepted divisor. The normalized divisor is the divisor shifted left by `lzc`, so its bit 15 is 1.
- R3: The seed index is normalized bits [14:12]. The seed byte for index i is floor(2048/(8+i)), limited to 255. Placing that byte in bits [15:8] forms the initial reciprocal estimate, with zeros in bits [7:0].
- R4: One refinement step computes t = (0 − hi16(r·v)) mod 2^16, then r = (hi16(t·r) << 1) mod 2^16. Here v is the normalized divisor and hi16 keeps bits [31:16] of the 32-bit product.
- R5: Exactly two refinement steps are applied. Divisor 17 gives `recip` 0xF0F0 with `lzc` 11. Divisor 1 gives 0xFFFE with `lzc` 15.
- R6: For a nonzero divisor whose `start` is sampled on clock edge E, `done` is high for exactly one cycle, after edge E+4. `busy` is high from edge E until that same edge.
- R7: A zero divisor gives `done` and `err` high after edge E itself, and `busy` stays low.
- R8: `err` is 0 with the `done` of every nonzero divisor.
- R9: A `start` pulse while `busy` is high is ignored. The result and the timing of the running request are unchanged.
- R10: `recip`, `lzc` and `err` hold their values from `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| divisor | input | 16 | Unsigned divisor, sampled with an accepted start |
| busy | output | 1 | A request is being refined |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last accepted divisor was zero |
| recip | output | 16 | Q16 reciprocal of the normalized divisor |
| lzc | output | 4 | Leading-zero count of the divisor |

## Verification
The hardest situation to reach from the ports is a second `start` arriving in the middle of a refinement. It has to come while the shared multiplier is between the two halves of a step. It also carries a divisor whose result would differ from the running one. The bench creates this on purpose. Two cycles after a request is accepted, it pulses `start` again with a different divisor. It then checks that the first divisor's result comes out after exactly four cycles. Random divisors drawn across every leading-zero count cover all eight seed entries. The divisors 1, 17, 0x8000, 0xFFFF and 0 are run as directed cases.

// File: rtl/nr_recip_pkg.sv
package nr_recip_pkg;
  typedef struct packed {
    logic load;    // capture divisor, count, seed
    logic mulEn;   // shared multiplier result is consumed this cycle
    logic phaseB;  // 0: t <= -hi(r*v), 1: r <= hi(t*r) << 1
  } nr_ctrl_t;
endpackage

// File: rtl/nr_recip_dp.sv
module nr_recip_dp
  import nr_recip_pkg::*;
#(
  parameter int W      = 16,
  parameter int SEED_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  nr_ctrl_t               ctl,
  input  logic [W-1:0]           divisor,
  output logic                   divZero,
  output logic [W-1:0]           recip,
  output logic [$clog2(W)-1:0]   lzc,
  output logic                   err
);
  localparam int LZW     = $clog2(W);
  localparam int SEEDS   = 1 << IDX_W;
  localparam int SEEDMAX = (1 << SEED_W) - 1;
  localparam int NUMER   = 1 << (SEED_W + IDX_W);

  logic [W-1:0]      vQ, rQ, tQ;
  logic [LZW-1:0]    nQ;
  logic              errQ;
  logic [LZW-1:0]    lzRaw;
  logic              found;
  logic [W-1:0]      normV;
  logic [IDX_W-1:0]  seedIdx;
  logic [SEED_W-1:0] seedRom [SEEDS];
  logic [W-1:0]      seedEst;
  logic [W-1:0]      mulA;
  logic [2*W-1:0]    prod;
  logic [W-1:0]      prodHi;

  assign divZero = (divisor == '0);

  always_comb begin
    lzRaw = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (divisor[i]) found = 1'b1;
        else            lzRaw = lzRaw + LZW'(1);
      end
    end
  end

  assign normV   = divisor << lzRaw;
  assign seedIdx = normV[W-2 -: IDX_W];

  for (genvar g = 0; g < SEEDS; g++) begin : g_seed
    localparam int QUOT = NUMER / (SEEDS + g);
    assign seedRom[g] = (QUOT > SEEDMAX) ? SEED_W'(SEEDMAX) : SEED_W'(QUOT);
  end

  assign seedEst = {seedRom[seedIdx], (W-SEED_W)'(0)};

  assign mulA   = ctl.phaseB ? tQ : vQ;
  assign prod   = mulA * rQ;
  assign prodHi = prod[2*W-1:W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vQ   <= '0;
      rQ   <= '0;
      tQ   <= '0;
      nQ   <= '0;
      errQ <= 1'b0;
    end else if (ctl.load) begin
      errQ <= divZero;
      if (!divZero) begin
        vQ <= normV;
        nQ <= lzRaw;
        rQ <= seedEst;
      end
    end else if (ctl.mulEn) begin
      if (!ctl.phaseB) tQ <= '0 - prodHi;
      else             rQ <= {prodHi[W-2:0], 1'b0};
    end
  end

  assign recip = rQ;
  assign lzc   = nQ;
  assign err   = errQ;

  assert_norm_msb_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mulEn |-> vQ[W-1]);
  assert_seed_top_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !divZero) |=> rQ[W-1]);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.mulEn) |=> ($stable(rQ) && $stable(nQ) && $stable(errQ)));
endmodule

// File: rtl/nr_recip_ctrl.sv
module nr_recip_ctrl
  import nr_recip_pkg::*;
#(
  parameter int STEPS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     divZero,
  output nr_ctrl_t ctl,
  output logic     busy,
  output logic     done
);
  localparam int STEP_W = $clog2(STEPS + 1);

  logic              busyQ, phaseQ, doneQ;
  logic [STEP_W-1:0] stepQ;
  logic              accept;

  assign accept = start && !busyQ;

  always_comb begin
    ctl.load   = accept;
    ctl.mulEn  = busyQ;
    ctl.phaseB = phaseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      phaseQ <= 1'b0;
      stepQ  <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        if (divZero) begin
          doneQ <= 1'b1;
        end else begin
          busyQ  <= 1'b1;
          phaseQ <= 1'b0;
          stepQ  <= '0;
        end
      end else if (busyQ) begin
        phaseQ <= ~phaseQ;
        if (phaseQ) begin
          if (stepQ == STEP_W'(STEPS - 1)) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            stepQ <= stepQ + STEP_W'(1);
          end
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_zero_fast_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accept && divZero) |=> (done && !busyQ));
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start) |=> (busyQ || done));
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busyQ);
endmodule

// File: rtl/nr_recip.sv
module nr_recip
  import nr_recip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [15:0] divisor,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] recip,
  output logic [3:0]  lzc
);
  nr_ctrl_t ctl;
  logic     divZero;

  nr_recip_ctrl #(.STEPS(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .divZero(divZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  nr_recip_dp #(.W(16), .SEED_W(8), .IDX_W(3)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divisor(divisor),
    .divZero(divZero), .recip(recip), .lzc(lzc), .err(err)
  );
endmodule

// File: tb/nr_recip_tb_top.sv
module nr_recip_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] divisor = '0;
  logic        busy, done, err;
  logic [15:0] recip;
  logic [3:0]  lzc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  nr_recip dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int refLz(input logic [15:0] d);
    int n = 0;
    while (n < 16 && !d[15-n]) n++;
    return n;
  endfunction

  function automatic logic [15:0] hi16(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p = 32'(a) * 32'(b);
    return p[31:16];
  endfunction

  function automatic logic [15:0] refRecip(input logic [15:0] d);
    logic [15:0] v = d << refLz(d);
    int idx = int'(v[14:12]);
    int sd = 2048 / (8 + idx);
    logic [15:0] r, t;
    if (sd > 255) sd = 255;
    r = 16'(sd) << 8;
    for (int s = 0; s < 2; s++) begin
      t = 16'h0 - hi16(r, v);
      r = hi16(t, r) << 1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h, expected %0h", tag, act, exp);
    end
  endtask

  // issue a request; optional extra start with other divisor two cycles later
  task automatic run(input logic [15:0] d, input bit intrude, input logic [15:0] d2);
    int lat = 0;
    int expLat = (d == 0) ? 0 : 4;
    logic [15:0] r;
    logic [3:0]  n;
    logic        e;
    @(negedge clk); start = 1'b1; divisor = d;
    @(negedge clk); start = 1'b0;
    if (d != 0) check("R6 busy", int'(busy), 1);
    while (!done && lat < 20) begin
      @(negedge clk); lat++;
      if (intrude && lat == 2) begin start = 1'b1; divisor = d2; end
      else begin start = 1'b0; divisor = d ^ 16'h5A5A; end
    end
    start = 1'b0;
    check(intrude ? "R9 latency" : "R6 latency", lat, expLat);
    if (d == 0) begin
      check("R7 err", int'(err), 1);
      check("R7 busy", int'(busy), 0);
    end else begin
      check("R8 err", int'(err), 0);
      check("R2 lzc", int'(lzc), refLz(d));
      check(intrude ? "R9 recip" : "R4 recip", int'(recip), int'(refRecip(d)));
      check("R6 not busy", int'(busy), 0);
    end
    r = recip; n = lzc; e = err;
    @(negedge clk);
    check("R6 pulse", int'(done), 0);
    @(negedge clk);
    check("R10 hold", int'({e, n, r}), int'({err, lzc, recip}));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 done", int'(done), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(err), 0);
    check("R1 recip", int'(recip), 0);
    check("R1 lzc", int'(lzc), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", int'({done, busy, err}), 0);

    run(16'd17, 1'b0, '0);
    check("R5 17 recip", int'(recip), 16'hF0F0);
    check("R5 17 lzc", int'(lzc), 11);
    run(16'd1, 1'b0, '0);
    check("R5 1 recip", int'(recip), 16'hFFFE);
    check("R5 1 lzc", int'(lzc), 15);
    run(16'h8000, 1'b0, '0);
    check("R3 seed idx0", int'(recip), 16'hFFFE);
    run(16'hFFFF, 1'b0, '0);
    run(16'd0, 1'b0, '0);
    run(16'd17, 1'b1, 16'd3);
    run(16'd0, 1'b0, '0);
    run(16'd5, 1'b0, '0);

    for (int k = 0; k < 400; k++) begin
      int sh = $urandom_range(0, 15);
      logic [15:0] d = 16'($urandom()) >> sh;
      if (d == 0) d = 16'd1;
      run(d, (k % 7) == 3, 16'($urandom()));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule